// File: doc/BRIEF.md
# Bidirectional Universal Bus Transceiver

This block passes an 18-bit word between an A bus and a B bus, one direction at a time or both at once. Each direction has its own storage element and three controls: a latch enable, a capture clock and an output enable. While the latch enable is high, the path is transparent and the output follows the input. While it is low, the element holds its data and loads a new word only on a rising edge of the capture clock.

The output enable of the A-to-B path is active high. The output enable of the B-to-A path is active low. Each bus is modelled with separate input, output and output-enable signals, so the block contains no internal tri-state logic. The surrounding logic resolves each bus from these signals. An active-low reset clears both storage elements asynchronously.

Top module: `ubt_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage elements are cleared. With both latch enables low and both outputs enabled, `b_out` and `a_out` read zero.
- R2: While `ab_le` is 1 and `ab_oe` is 1, `b_out` equals `a_in` in the same cycle.
- R3: While `ab_le` is 0 and `ab_clk` is held at either level, changes on `a_in` leave `b_out` unchanged.
- R4: While `ab_le` is 0, a rising edge of `ab_clk` loads `a_in` and the new word appears on `b_out`. A falling edge loads nothing.
- R5: When `ab_le` falls, the word last passed through transparently stays on `b_out` until the next rising edge of `ab_clk`.
- R6: `b_oe` equals `ab_oe`. While `ab_oe` is 0, `b_out` reads zero and the stored word is kept.
- R7: The B-to-A path follows R2 to R5 from `b_in` to `a_out`, using `ba_le` and `ba_clk`.
- R8: `a_oe` is the inverse of `ba_oe_n`. While `ba_oe_n` is 1, `a_out` reads zero and the stored word is kept.
- R9: Activity on one direction's input, latch enable or clock does not change the word stored in the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both storage elements |
| a_in | input | WIDTH | Word received from the A bus |
| a_out | output | WIDTH | Word driven onto the A bus; zero when not enabled |
| a_oe | output | 1 | The block drives the A bus |
| b_in | input | WIDTH | Word received from the B bus |
| b_out | output | WIDTH | Word driven onto the B bus; zero when not enabled |
| b_oe | output | 1 | The block drives the B bus |
| ab_le | input | 1 | A-to-B transparent mode when high |
| ab_clk | input | 1 | A-to-B capture clock, rising edge |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A transparent mode when high |
| ba_clk | input | 1 | B-to-A capture clock, rising edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
Some properties hold at every instant, so the assertions check them continuously:
- In transparent mode, each output equals the opposite input.
- A disabled output reads zero.
- The two enable outputs follow their controls with the stated polarities.

Other behaviour depends on history and can only be shown by the bench's ordered scenarios:
- holding data against a steady clock at either level;
- loading on a rising edge but not on a falling edge;
- keeping the last transparent word when the latch enable falls;
- keeping stored data across a disable;
- isolation between the two directions.

The bench also watches each bus for a cycle in which the block and the external driver are both enabled.

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ab_oe,
  input  logic             ba_le,
  input  logic             ba_clk,
  input  logic             ba_oe_n
);

  logic [WIDTH-1:0] ab_q;
  logic [WIDTH-1:0] ba_q;

  // A rising clock loads the element; a falling latch enable freezes the transparent word.
  always_ff @(posedge ab_clk or negedge ab_le or negedge rst_n) begin
    if (!rst_n) ab_q <= '0;
    else        ab_q <= a_in;
  end

  always_ff @(posedge ba_clk or negedge ba_le or negedge rst_n) begin
    if (!rst_n) ba_q <= '0;
    else        ba_q <= b_in;
  end

  assign b_oe  = ab_oe;
  assign b_out = ab_oe ? (ab_le ? a_in : ab_q) : '0;

  assign a_oe  = ~ba_oe_n;
  assign a_out = a_oe ? (ba_le ? b_in : ba_q) : '0;

endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
  parameter int WIDTH = 18
) (
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic             ab_le,
  input logic             ab_clk,
  input logic             ab_oe,
  input logic             ba_le,
  input logic             ba_clk,
  input logic             ba_oe_n
);

  always_comb begin
    // R2
    ab_transparent_chk: assert (!(rst_n && ab_le && b_oe) || b_out == a_in);
    // R6
    ab_disabled_zero_chk: assert (b_oe || b_out == '0);
    // R6
    ab_enable_pol_chk: assert (b_oe == ab_oe);
    // R7
    ba_transparent_chk: assert (!(rst_n && ba_le && a_oe) || a_out == b_in);
    // R8
    ba_disabled_zero_chk: assert (a_oe || a_out == '0);
    // R8
    ba_enable_pol_chk: assert (a_oe != ba_oe_n);
  end

  logic unused_clks;
  assign unused_clks = ab_clk ^ ba_clk;

endmodule

bind ubt_xcvr ubt_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/ubt_xcvr_tb.sv
module ubt_xcvr_tb;
  localparam int W = 18;

  logic clk = 0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic [W-1:0] a_in, a_out, b_in, b_out;
  logic         a_oe, b_oe;
  logic         ab_le, ab_clk, ab_oe, ba_le, ba_clk, ba_oe_n;
  logic         ext_a_drv, ext_b_drv;

  int total = 0;
  int fails = 0;
  bit done = 0;

  ubt_xcvr #(.WIDTH(W)) u_dut (
    .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n)
  );

  function automatic logic [W-1:0] pat(int i);
    logic [31:0] v;
    v = i * 32'h0000_F0F1 + 32'h0001_5A5A;
    v = v ^ (v << 9) ^ (i << 3);
    return v[W-1:0];
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    #3;
  endtask

  // bus contention monitor (R6, R8)
  always @(negedge clk) if (!done && rst_n) begin
    total++;
    if ((a_oe && ext_a_drv) || (b_oe && ext_b_drv)) begin
      fails++;
      $display("FAIL R8/R6 contention: a_oe=%b ext_a=%b b_oe=%b ext_b=%b expected no overlap",
               a_oe, ext_a_drv, b_oe, ext_b_drv);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 0; a_in = '1; b_in = '1;
    ab_le = 0; ab_clk = 0; ab_oe = 1; ba_le = 0; ba_clk = 0; ba_oe_n = 0;
    ext_a_drv = 0; ext_b_drv = 0;
    repeat (3) @(posedge clk);
    settle();
    chk("R1 reset b_out", b_out, '0);
    chk("R1 reset a_out", a_out, '0);
    chk("R6 b_oe", {17'b0, b_oe}, 18'd1);
    chk("R8 a_oe", {17'b0, a_oe}, 18'd1);
    rst_n = 1;

    // A to B direction
    @(posedge clk); ba_oe_n = 1; settle(); ext_a_drv = 1;
    chk("R8 a_out disabled", a_out, '0);
    for (int i = 0; i < 16; i++) begin
      logic [W-1:0] k;
      k = pat(i);
      @(posedge clk); ab_le = 1; a_in = k; settle();
      chk("R2 transparent", b_out, k);
      ab_le = 0; settle(); a_in = ~k; settle();
      chk("R5 le fall keeps", b_out, k);
      ab_clk = 1; settle();
      chk("R4 rising capture", b_out, ~k);
      a_in = pat(i + 1); settle();
      chk("R3 hold clk high", b_out, ~k);
      ab_clk = 0; settle();
      chk("R4 no fall capture", b_out, ~k);
      a_in = pat(i + 2); settle();
      chk("R3 hold clk low", b_out, ~k);
      ab_oe = 0; settle();
      chk("R6 disabled zero", b_out, '0);
      chk("R6 b_oe low", {17'b0, b_oe}, '0);
      ab_clk = 1; settle(); ab_clk = 0; a_in = k; settle();
      ab_oe = 1; settle();
      chk("R6 kept across disable", b_out, pat(i + 2));
    end

    // B to A direction
    @(posedge clk); ab_oe = 0; settle(); ext_b_drv = 1;
    ext_a_drv = 0; settle(); ba_oe_n = 0; settle();
    for (int i = 0; i < 16; i++) begin
      logic [W-1:0] k;
      k = pat(i + 40);
      @(posedge clk); ba_le = 1; b_in = k; settle();
      chk("R7 transparent", a_out, k);
      ba_le = 0; settle(); b_in = ~k; settle();
      chk("R7 le fall keeps", a_out, k);
      ba_clk = 1; settle();
      chk("R7 rising capture", a_out, ~k);
      b_in = k ^ 18'h00F0F; settle();
      chk("R7 hold clk high", a_out, ~k);
      ba_clk = 0; settle();
      chk("R7 no fall capture", a_out, ~k);
      ba_oe_n = 1; settle();
      chk("R8 disabled zero", a_out, '0);
      chk("R8 a_oe low", {17'b0, a_oe}, '0);
      ba_oe_n = 0; settle();
      chk("R8 kept across disable", a_out, ~k);
    end

    // R9: activity on A-to-B must not disturb stored B-to-A word
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      a_in = pat(i + 90); ab_le = 1; settle(); ab_le = 0; settle();
      ab_clk = 1; settle(); ab_clk = 0; settle();
      chk("R9 ba isolated", a_out, ~pat(55));
    end
    // and the reverse: B-to-A activity must not disturb stored A-to-B word
    ba_oe_n = 1; settle(); ext_a_drv = 1; ext_b_drv = 0; settle();
    for (int i = 0; i < 8; i++) begin
      b_in = pat(i + 120); ba_le = 1; settle(); ba_le = 0; settle();
      ba_clk = 1; settle(); ba_clk = 0; settle();
    end
    ab_oe = 1; settle();
    chk("R9 ab isolated", b_out, pat(97));

    // R1: reset mid-run clears stored data
    @(posedge clk); rst_n = 0; settle();
    chk("R1 mid-run clear b_out", b_out, '0);
    ab_oe = 0; settle(); ext_b_drv = 1; ext_a_drv = 0; settle(); ba_oe_n = 0; settle();
    chk("R1 mid-run clear a_out", a_out, '0);
    rst_n = 1; settle();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule